// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes stereo PCM from a three-wire serial audio link (bit clock, word clock, serial data) and turns it into parallel left and right samples. The three link wires are oversampled by the system clock. A rising bit-clock edge is found by comparing registered copies of the bit clock. The word clock and the data bit are taken from the same sampling edge.

A two-bit format select picks left-justified, right-justified or I2S framing. A width select picks 16-bit or 18-bit words. Both selects may change at any time. The receiver captures them on the first bit of each word and holds them for the rest of that word. Samples come out as signed 18-bit values. A 16-bit word is placed in the upper bits, with two zero bits below it. Both channel outputs update together, and a one-cycle strobe marks each completed stereo pair.

The controller is a four-state machine:
- `ST_IDLE`: waits for the first bit-clock rise after reset, then takes `T_PRIME` to `ST_ALIGN`.
- `ST_ALIGN`: discards the partial word in progress.
- `ST_LEFT` and `ST_RIGHT`: each word-clock change (`T_BOUNDARY`) closes the current word and moves to the state of the new word's channel.
- Closing a left word stores it.
- Closing a right word publishes the pair, but only when a left word was stored before it.

Each channel slot must hold at least one more bit-clock period than the word width.

Top module: `audrx_top`

## Requirements
- R1: While `rst_n` is low, and after it is released, `left_out` and `right_out` read zero and `frame_valid` is low until the first complete stereo pair.
- R2: With `fmt_sel` = 00 or 11 (left-justified), the MSB is on the first bit-clock rise after a word-clock change, word clock high means left, and the bits that follow run MSB to LSB.
- R3: With `fmt_sel` = 01 (right-justified), the sample is the last N bits received before the word-clock change (N = 16 or 18), LSB last, and word clock high means left.
- R4: With `fmt_sel` = 10 (I2S), the MSB is on the second bit-clock rise after a word-clock change, and word clock low means left.
- R5: With `wide18` = 1 the word has 18 bits and fills bits 17..0. With `wide18` = 0 the word has 16 bits, is placed in bits 17..2, and bits 1..0 read zero.
- R6: Data bits outside the word's N-bit position within the slot have no effect on the output.
- R7: Format and width are captured at the first bit-clock rise of each word. Changes at any later point in that word do not affect how it is decoded.
- R8: `frame_valid` is high for exactly one clock per stereo pair, after the right word closes on the next word-clock change. Both outputs change only in that cycle.
- R9: The partial word seen after reset is discarded. A right word that is not preceded by a complete left word produces no `frame_valid`.
- R10: `sdata` is taken only at rising bit-clock edges. Changes while the bit clock is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the link |
| rst_n | input | 1 | Synchronous power-down/reset, active low |
| bck | input | 1 | Serial bit clock |
| lrck | input | 1 | Word (channel) clock |
| sdata | input | 1 | Serial data |
| fmt_sel | input | 2 | Framing: 00 LJ, 01 RJ, 10 I2S, 11 LJ |
| wide18 | input | 1 | 1 = 18-bit words, 0 = 16-bit words |
| left_out | output | 18 | Left sample, signed |
| right_out | output | 18 | Right sample, signed |
| frame_valid | output | 1 | One-cycle strobe for a new stereo pair |

## Verification
The assertions check the following on every cycle:
- the reset clearing of the outputs;
- the single-cycle width of the pair strobe;
- that the outputs stay unchanged outside the strobe;
- that the strobe comes only from a closing right word and follows a real rising bit-clock edge.

Bit alignment for each framing, width packing, filler bits, data that moves while the bit clock is high, format changes in the middle of a word, and discarding the first partial word are all about data values. Only the bench scenarios can show these: they compare the decoded samples with values computed from the transmitted words.

// File: rtl/audrx_pkg.sv
package audrx_pkg;
    typedef enum logic [1:0] {
        FMT_LJ  = 2'b00,
        FMT_RJ  = 2'b01,
        FMT_I2S = 2'b10,
        FMT_RSV = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_ALIGN = 2'b01,
        ST_LEFT  = 2'b10,
        ST_RIGHT = 2'b11
    } rx_state_e;
endpackage

// File: rtl/audrx_sampler.sv
module audrx_sampler
    import audrx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bck,
    input  logic lrck,
    input  logic sdata,
    input  fmt_e fmt_in,
    input  logic wide_in,
    output logic bit_stb,
    output logic lr_s,
    output logic sd_s,
    output fmt_e fmt_s,
    output logic wide_s
);
    logic bck_q;
    logic bck_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bck_q  <= 1'b0;
            bck_d  <= 1'b0;
            lr_s   <= 1'b0;
            sd_s   <= 1'b0;
            fmt_s  <= FMT_LJ;
            wide_s <= 1'b0;
        end else begin
            bck_q  <= bck;
            bck_d  <= bck_q;
            lr_s   <= lrck;
            sd_s   <= sdata;
            fmt_s  <= fmt_in;
            wide_s <= wide_in;
        end
    end

    // one-cycle pulse on a rising bit clock
    assign bit_stb = bck_q & ~bck_d;
endmodule

// File: rtl/audrx_shifter.sv
module audrx_shifter
    import audrx_pkg::*;
#(
    parameter int WORD_W  = 18,
    parameter int SHORT_W = 16,
    parameter int CNT_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              boundary,
    input  logic              sd,
    input  fmt_e              fmt_new,
    input  logic              wide_new,
    output logic [WORD_W-1:0] word_val
);
    localparam int PAD_W = WORD_W - SHORT_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    fmt_e              fmt_q;
    logic              wide_q;
    logic [CNT_W-1:0]  bitcnt;
    logic [CNT_W-1:0]  nbits;
    logic [WORD_W-1:0] shreg;
    logic              take;

    assign nbits = wide_q ? CNT_W'(WORD_W) : CNT_W'(SHORT_W);

    // which slot positions belong to the word (format latched for this word)
    always_comb begin
        unique case (fmt_q)
            FMT_RJ:  take = 1'b1;
            FMT_I2S: take = (bitcnt != '0) && (bitcnt <= nbits);
            default: take = (bitcnt < nbits);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q  <= FMT_LJ;
            wide_q <= 1'b0;
            bitcnt <= '0;
            shreg  <= '0;
        end else if (bit_stb) begin
            if (boundary) begin
                fmt_q  <= fmt_new;
                wide_q <= wide_new;
                bitcnt <= CNT_W'(1);
                unique case (fmt_new)
                    FMT_RJ:  shreg <= {shreg[WORD_W-2:0], sd};
                    FMT_I2S: shreg <= '0;
                    default: shreg <= {{(WORD_W-1){1'b0}}, sd};
                endcase
            end else begin
                if (bitcnt != CNT_MAX) begin
                    bitcnt <= bitcnt + CNT_W'(1);
                end
                if (take) begin
                    shreg <= {shreg[WORD_W-2:0], sd};
                end
            end
        end
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign word_val = wide_q ? shreg : {shreg[SHORT_W-1:0], {PAD_W{1'b0}}};
        end else begin : g_nopad
            assign word_val = shreg;
        end
    endgenerate
endmodule

// File: rtl/audrx_top.sv
module audrx_top
    import audrx_pkg::*;
#(
    parameter int WORD_W     = 18,
    parameter int SHORT_W    = 16,
    parameter int SLOT_CNT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bck,
    input  logic              lrck,
    input  logic              sdata,
    input  logic [1:0]        fmt_sel,
    input  logic              wide18,
    output logic [WORD_W-1:0] left_out,
    output logic [WORD_W-1:0] right_out,
    output logic              frame_valid
);
    rx_state_e         state;
    rx_state_e         state_nx;
    logic              bit_stb;
    logic              lr_s;
    logic              sd_s;
    fmt_e              fmt_s;
    logic              wide_s;
    logic              lr_prev;
    logic              boundary;
    logic              chan_left;
    logic              have_left;
    logic [WORD_W-1:0] word_val;
    logic [WORD_W-1:0] left_hold;

    audrx_sampler u_sampler (
        .clk     (clk),
        .rst_n   (rst_n),
        .bck     (bck),
        .lrck    (lrck),
        .sdata   (sdata),
        .fmt_in  (fmt_e'(fmt_sel)),
        .wide_in (wide18),
        .bit_stb (bit_stb),
        .lr_s    (lr_s),
        .sd_s    (sd_s),
        .fmt_s   (fmt_s),
        .wide_s  (wide_s)
    );

    audrx_shifter #(
        .WORD_W  (WORD_W),
        .SHORT_W (SHORT_W),
        .CNT_W   (SLOT_CNT_W)
    ) u_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_stb  (bit_stb),
        .boundary (boundary),
        .sd       (sd_s),
        .fmt_new  (fmt_s),
        .wide_new (wide_s),
        .word_val (word_val)
    );

    assign boundary  = bit_stb && (state != ST_IDLE) && (lr_s != lr_prev);
    assign chan_left = (fmt_s == FMT_I2S) ? ~lr_s : lr_s;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            lr_prev <= 1'b0;
        end else begin
            state <= state_nx;
            if (bit_stb) begin
                lr_prev <= lr_s;
            end
        end
    end

    // next state: T_PRIME out of ST_IDLE, T_BOUNDARY elsewhere
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (bit_stb) state_nx = ST_ALIGN;
            end
            ST_ALIGN, ST_LEFT, ST_RIGHT: begin
                if (boundary) state_nx = chan_left ? ST_LEFT : ST_RIGHT;
            end
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_hold   <= '0;
            have_left   <= 1'b0;
            left_out    <= '0;
            right_out   <= '0;
            frame_valid <= 1'b0;
        end else begin
            frame_valid <= 1'b0;
            if (boundary) begin
                unique case (state)
                    ST_LEFT: begin
                        left_hold <= word_val;
                        have_left <= 1'b1;
                    end
                    ST_RIGHT: begin
                        if (have_left) begin
                            left_out    <= left_hold;
                            right_out   <= word_val;
                            frame_valid <= 1'b1;
                        end
                        have_left <= 1'b0;
                    end
                    default: have_left <= 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/audrx_chk.sv
module audrx_chk
    import audrx_pkg::*;
#(
    parameter int WORD_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bck,
    input logic              frame_valid,
    input logic [WORD_W-1:0] left_out,
    input logic [WORD_W-1:0] right_out,
    input logic [1:0]        state_q
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (left_out == '0 && right_out == '0 && !frame_valid));

    assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);

    assert_outputs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid || ($stable(left_out) && $stable(right_out)));

    assert_valid_from_right_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> ($past(state_q) == 2'(ST_RIGHT)));

    assert_valid_after_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> ($past(bck, 2) && !$past(bck, 3)));
endmodule

bind audrx_top audrx_chk #(.WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bck         (bck),
    .frame_valid (frame_valid),
    .left_out    (left_out),
    .right_out   (right_out),
    .state_q     (state)
);

// File: tb/test_audrx_top.sv
module test_audrx_top;
    localparam int SLOT = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bck = 1'b0;
    logic        lrck = 1'b0;
    logic        sdata = 1'b0;
    logic [1:0]  fmt_sel = 2'b00;
    logic        wide18 = 1'b1;
    logic [17:0] left_out;
    logic [17:0] right_out;
    logic        frame_valid;

    int checks = 0;
    int fails = 0;
    int wr_i = 0;
    int rd_i = 0;
    logic [17:0] exp_l [0:255];
    logic [17:0] exp_r [0:255];
    string       exp_tag [0:255];
    logic        prev_valid = 1'b0;
    logic [31:0] seed_dummy;

    always #4 clk = ~clk;

    audrx_top i_audrx_top (
        .clk(clk), .rst_n(rst_n), .bck(bck), .lrck(lrck), .sdata(sdata),
        .fmt_sel(fmt_sel), .wide18(wide18),
        .left_out(left_out), .right_out(right_out), .frame_valid(frame_valid)
    );

    function automatic logic [17:0] exp_val(input logic wd, input logic [17:0] w);
        return wd ? w : {w[15:0], 2'b00};
    endfunction

    function automatic logic slot_bit(input logic [1:0] f, input logic wd,
                                      input logic [17:0] w, input int i, input logic fill);
        int n = wd ? 18 : 16;
        if (f == 2'b01) begin
            if (i >= SLOT - n) return w[SLOT-1-i];
        end else if (f == 2'b10) begin
            if (i >= 1 && i <= n) return w[n-i];
        end else begin
            if (i < n) return w[n-1-i];
        end
        return fill;
    endfunction

    // pair monitor (R2..R8 data, R9 no stray strobe)
    always @(negedge clk) begin
        if (rst_n && frame_valid) begin
            checks++;
            if (prev_valid) begin
                fails++;
                $display("FAIL R8 strobe wider than one cycle: actual=2 cycles expected=1");
            end
            if (rd_i >= wr_i) begin
                fails++;
                $display("FAIL R9 unexpected pair: actual L=%h R=%h expected none", left_out, right_out);
            end else begin
                if (left_out !== exp_l[rd_i] || right_out !== exp_r[rd_i]) begin
                    fails++;
                    $display("FAIL %s pair %0d: actual L=%h R=%h expected L=%h R=%h",
                             exp_tag[rd_i], rd_i, left_out, right_out, exp_l[rd_i], exp_r[rd_i]);
                end
                rd_i++;
            end
        end
        prev_valid <= frame_valid;
    end

    task automatic check_zero(input string when);
        checks++;
        if (left_out !== '0 || right_out !== '0 || frame_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 %s: actual L=%h R=%h v=%b expected 0 0 0",
                     when, left_out, right_out, frame_valid);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bck = 1'b0;
        repeat (5) @(negedge clk);
        check_zero("in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_zero("after release");
        wr_i = 0;
        rd_i = 0;
    endtask

    // R10: data wiggles while bck is high
    task automatic send_bit(input logic lr, input logic d);
        @(negedge clk);
        bck = 1'b0;
        lrck = lr;
        sdata = d;
        repeat (2) @(negedge clk);
        bck = 1'b1;
        @(negedge clk);
        sdata = 1'($urandom);
        @(negedge clk);
    endtask

    // R6 random fillers, R7 select glitch mid-word
    task automatic send_word(input logic [1:0] f, input logic wd,
                             input logic is_left, input logic [17:0] w);
        logic lr = (f == 2'b10) ? ~is_left : is_left;
        for (int i = 0; i < SLOT; i++) begin
            if (i == 3) begin
                fmt_sel = 2'($urandom);
                wide18 = 1'($urandom);
            end
            if (i == SLOT - 1) begin
                fmt_sel = f;
                wide18 = wd;
            end
            send_bit(lr, slot_bit(f, wd, w, i, 1'($urandom)));
        end
    endtask

    task automatic send_frame(input logic [1:0] f, input logic wl, input logic wr,
                              input logic [17:0] l, input logic [17:0] r, input string tag);
        fmt_sel = f;
        wide18 = wl;
        exp_l[wr_i] = exp_val(wl, l);
        exp_r[wr_i] = exp_val(wr, r);
        exp_tag[wr_i] = tag;
        wr_i++;
        send_word(f, wl, 1'b1, l);
        wide18 = wr;
        send_word(f, wr, 1'b0, r);
    endtask

    task automatic run_session(input logic [1:0] f, input int nfr, input bit odd_start,
                               input bit mix, input bit directed, input string tag);
        logic lvl_left = (f == 2'b10) ? 1'b0 : 1'b1;
        logic [1:0] fk;
        do_reset();
        fmt_sel = f;
        wide18 = 1'b1;
        if (odd_start) begin
            for (int i = 0; i < 3; i++) send_bit(lvl_left, 1'($urandom));
            send_word(f, 1'b1, 1'b0, 18'($urandom)); // R9: orphan right word
        end else begin
            for (int i = 0; i < 5; i++) send_bit(~lvl_left, 1'($urandom));
        end
        for (int k = 0; k < nfr; k++) begin
            fk = f;
            if (mix) begin
                case ($urandom % 3)
                    0: fk = 2'b00;
                    1: fk = 2'b01;
                    default: fk = 2'b11;
                endcase
            end
            if (directed && k == 0)
                send_frame(fk, 1'b1, 1'b1, 18'h3FFFF, 18'h20000, tag);
            else if (directed && k == 1)
                send_frame(fk, 1'b0, 1'b0, 18'h08000, 18'h07FFF, tag);
            else if (directed && k == 2)
                send_frame(fk, 1'b1, 1'b0, 18'h00001, 18'h0FFFF, tag);
            else
                send_frame(fk, 1'($urandom), 1'($urandom), 18'($urandom), 18'($urandom), tag);
        end
        for (int i = 0; i < 2; i++) send_bit(lvl_left, 1'($urandom));
        repeat (10) @(negedge clk);
        checks++;
        if (rd_i != wr_i) begin
            fails++;
            $display("FAIL R8 pair count (%s): actual=%0d expected=%0d", tag, rd_i, wr_i);
        end
    endtask

    initial begin
        seed_dummy = $urandom(32'd2024);
        run_session(2'b00, 8, 1'b0, 1'b0, 1'b1, "R2 R5 R6 R10");
        run_session(2'b01, 8, 1'b0, 1'b0, 1'b1, "R3 R5 R6");
        run_session(2'b10, 8, 1'b0, 1'b0, 1'b1, "R4 R5 R6");
        run_session(2'b00, 12, 1'b0, 1'b1, 1'b0, "R7 R2 R3");
        run_session(2'b10, 4, 1'b1, 1'b0, 1'b0, "R9 R4");
        run_session(2'b01, 4, 1'b1, 1'b0, 1'b0, "R9 R3");
        run_session(2'b11, 4, 1'b0, 1'b0, 1'b1, "R2 R5");
        do_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule